// File: doc/BRIEF.md
# Multi-Domain Power-of-Two Clock Enable Divider

This block takes a single fast clock from a PLL and produces six derived clock-enable strobes, one per clock domain: processor core, signal-processor core, signal-processor memory-management unit, on-chip traffic controller, peripheral bus and display controller. Each domain runs at the source rate divided by 1, 2, 4 or 8. The ratio comes from a 2-bit exponent field in one 16-bit control word. A further strobe, for a watchdog timer, runs at the source rate divided by a fixed 14.

Software writes the control word through a simple write-strobe port. Every written word first passes through a legalizing clamp. The clamp rewrites the exponents so that the domain ratios obey fixed ordering rules between domains. The legalized word is stored and can be read back. The stored ratios are handed to the dividers only at a common 8-cycle phase boundary, where every domain counter realigns, so the domains never drift out of step with one another. Each domain also has its own gate input, which silences that domain's strobe without disturbing its phase.

Top module: `clk_ratio_divider`

## Requirements
- R1: Control-word layout: peripheral exponent in bits 1:0, display exponent in bits 3:2, processor-core exponent in bits 5:4, signal-processor exponent in bits 7:6, traffic-controller exponent in bits 9:8, and memory-management exponent in bits 11:10. A domain with exponent e divides by 2^e. The `tick` bit order is peripheral 0, display 1, core 2, signal processor 3, traffic controller 4, memory management 5. Reset loads 0x0000, so every domain strobes on every cycle.
- R2: The memory-management exponent is clamped up to the signal-processor exponent when below it, and down to that exponent plus one when above that.
- R3: After the R2 step, the traffic-controller exponent is raised to at least the core exponent and to at least the memory-management exponent.
- R4: After the R3 step, the traffic-controller exponent is lowered to at most the display exponent and to at most the peripheral exponent. When a lower bound from R3 conflicts with an upper bound, the upper bound wins.
- R5: A write takes effect on `rd_data` in the cycle after `wr_en` is sampled, showing the legalized word. Bits 15:12 are stored unchanged.
- R6: Without a write, `rd_data` holds its value.
- R7: An enabled domain with exponent e pulses `tick` for exactly one cycle in every 2^e cycles.
- R8: While a domain's `gate_en` bit is low, its `tick` stays low, and its counter keeps its phase.
- R9: Stored ratios are applied only at the end of each 8-cycle phase frame. Writes never shift the frame: a domain dividing by 8 keeps an exact 8-cycle spacing across writes, and every enabled domain pulses in the same cycle as it.
- R10: `wdt_tick` pulses for one cycle in every 14 cycles, independently of the control word and the gates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock from the PLL |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word to be legalized and stored |
| rd_data | output | 16 | Stored, legalized control word |
| gate_en | input | 6 | Per-domain strobe enable, bit order as in R1 |
| tick | output | 6 | Per-domain single-cycle clock-enable strobes |
| wdt_tick | output | 1 | Watchdog strobe at one fourteenth of the source rate |

## Verification
The assertions assume that the clamp rules can be checked on the stored word alone. This holds because only legalized values ever reach the register. The lower-bound rule is asserted only when it does not conflict with an upper bound, because the upper bound wins in that case. The stimulus drives `wr_en`, `wr_data` and `gate_en` only at the falling edge, so every write is a clean single-cycle strobe. The rate and coincidence checks use windows that are whole multiples of 8 and 14 cycles, and they start only after a full frame has passed since the last write. This makes their expected counts independent of where a write fell in the frame.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int EXP_W   = 2;
    localparam int NUM_DOM = 6;

    typedef logic [EXP_W-1:0] exp_t;

    // Domain index = position in the tick vector; field offset = index * EXP_W
    localparam int DOM_PER = 0;
    localparam int DOM_LCD = 1;
    localparam int DOM_CPU = 2;
    localparam int DOM_SPU = 3;
    localparam int DOM_XBAR = 4;
    localparam int DOM_MMU = 5;

    typedef struct packed {
        logic [3:0] spare;
        exp_t       mmu;
        exp_t       xbar;
        exp_t       spu;
        exp_t       cpu;
        exp_t       lcd;
        exp_t       per;
    } ctl_word_t;

    localparam int CTL_W = $bits(ctl_word_t);

    function automatic exp_t exp_max(exp_t a, exp_t b);
        return (a > b) ? a : b;
    endfunction

    function automatic exp_t exp_min(exp_t a, exp_t b);
        return (a < b) ? a : b;
    endfunction

    function automatic exp_t dom_exp(ctl_word_t w, int idx);
        exp_t e;
        case (idx)
            DOM_PER:  e = w.per;
            DOM_LCD:  e = w.lcd;
            DOM_CPU:  e = w.cpu;
            DOM_SPU:  e = w.spu;
            DOM_XBAR: e = w.xbar;
            default:  e = w.mmu;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/ratio_legalizer.sv
module ratio_legalizer
    import clkdiv_pkg::*;
(
    input  ctl_word_t raw,
    output ctl_word_t legal
);

    ctl_word_t s_mmu;
    ctl_word_t s_floor;
    logic [EXP_W:0] spu_plus;

    // Stage 1: memory-management exponent bracketed by the signal-processor one
    always_comb begin
        s_mmu    = raw;
        spu_plus = {1'b0, raw.spu} + 1'b1;
        if (raw.mmu < raw.spu)
            s_mmu.mmu = raw.spu;
        else if ({1'b0, raw.mmu} > spu_plus)
            s_mmu.mmu = spu_plus[EXP_W-1:0];
    end

    // Stage 2: traffic-controller exponent floors
    always_comb begin
        s_floor      = s_mmu;
        s_floor.xbar = exp_max(exp_max(s_mmu.xbar, s_mmu.cpu), s_mmu.mmu);
    end

    // Stage 3: traffic-controller exponent ceilings, applied last so they win
    always_comb begin
        legal      = s_floor;
        legal.xbar = exp_min(exp_min(s_floor.xbar, s_floor.lcd), s_floor.per);
    end

endmodule

// File: rtl/ratio_ctl_reg.sv
module ratio_ctl_reg
    import clkdiv_pkg::*;
#(
    parameter logic [CTL_W-1:0] RST_VAL = '0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  ctl_word_t wr_word,
    input  logic      commit,
    output ctl_word_t shadow,
    output ctl_word_t active
);

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= ctl_word_t'(RST_VAL);
            active <= ctl_word_t'(RST_VAL);
        end else begin
            if (wr_en)
                shadow <= wr_word;
            if (commit)
                active <= shadow;
        end
    end

endmodule

// File: rtl/phase_gen.sv
module phase_gen #(
    parameter int PH_W = 3
) (
    input  logic clk,
    input  logic rst,
    output logic frame_end
);

    logic [PH_W-1:0] ph;

    always_ff @(posedge clk) begin
        if (rst) ph <= '0;
        else     ph <= ph + 1'b1;
    end

    assign frame_end = &ph;

endmodule

// File: rtl/domain_tick.sv
module domain_tick
    import clkdiv_pkg::*;
#(
    parameter int PH_W = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic realign,
    input  exp_t ratio_exp,
    input  logic gate,
    output logic tick
);

    logic [PH_W-1:0] cnt;
    logic [PH_W-1:0] lim;

    assign lim = ~({PH_W{1'b1}} << ratio_exp);

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (realign)    cnt <= '0;
        else if (cnt == lim) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    assign tick = gate & (cnt == lim);

endmodule

// File: rtl/wdt_gen.sv
module wdt_gen #(
    parameter int DIV = 14
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);

    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

endmodule

// File: rtl/clk_ratio_divider.sv
module clk_ratio_divider
    import clkdiv_pkg::*;
#(
    parameter int                 WDT_DIV = 14,
    parameter logic [CTL_W-1:0]   RST_VAL = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [CTL_W-1:0]   wr_data,
    output logic [CTL_W-1:0]   rd_data,
    input  logic [NUM_DOM-1:0] gate_en,
    output logic [NUM_DOM-1:0] tick,
    output logic               wdt_tick
);

    localparam int MAX_EXP = (1 << EXP_W) - 1;
    localparam int PH_W    = MAX_EXP;

    ctl_word_t legal_w;
    ctl_word_t shadow;
    ctl_word_t active;
    logic      frame_end;

    ratio_legalizer u_legal (
        .raw   (ctl_word_t'(wr_data)),
        .legal (legal_w)
    );

    ratio_ctl_reg #(.RST_VAL(RST_VAL)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_word (legal_w),
        .commit  (frame_end),
        .shadow  (shadow),
        .active  (active)
    );

    phase_gen #(.PH_W(PH_W)) u_phase (
        .clk       (clk),
        .rst       (rst),
        .frame_end (frame_end)
    );

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        domain_tick #(.PH_W(PH_W)) u_tick (
            .clk       (clk),
            .rst       (rst),
            .realign   (frame_end),
            .ratio_exp (dom_exp(active, d)),
            .gate      (gate_en[d]),
            .tick      (tick[d])
        );
    end

    wdt_gen #(.DIV(WDT_DIV)) u_wdt (
        .clk  (clk),
        .rst  (rst),
        .tick (wdt_tick)
    );

    assign rd_data = shadow;

endmodule

// File: rtl/clk_ratio_divider_chk.sv
module clk_ratio_divider_chk
    import clkdiv_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic [CTL_W-1:0]   wr_data,
    input logic [CTL_W-1:0]   rd_data,
    input logic [NUM_DOM-1:0] gate_en,
    input logic [NUM_DOM-1:0] tick,
    input logic               wdt_tick
);

    ctl_word_t r;
    assign r = ctl_word_t'(rd_data);

    AST_MMU_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (r.mmu >= r.spu) && ({1'b0, r.mmu} <= ({1'b0, r.spu} + 3'd1))); // R2

    AST_XBAR_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (r.cpu <= r.lcd && r.cpu <= r.per && r.mmu <= r.lcd && r.mmu <= r.per)
        |-> (r.xbar >= r.cpu && r.xbar >= r.mmu)); // R3

    AST_XBAR_CEILING: assert property (@(posedge clk) disable iff (rst)
        (r.xbar <= r.lcd) && (r.xbar <= r.per)); // R4

    AST_SPARE_PASS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[15:12] == $past(wr_data[15:12]))); // R5

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(rd_data)); // R6

    AST_GATE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (tick & ~gate_en) == '0); // R8

    AST_WDT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wdt_tick |=> !wdt_tick); // R10

endmodule

bind clk_ratio_divider clk_ratio_divider_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .gate_en  (gate_en),
    .tick     (tick),
    .wdt_tick (wdt_tick)
);

// File: tb/clk_ratio_divider_tb.sv
module clk_ratio_divider_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;

    // {written word, expected read-back}; fields per R1
    localparam logic [31:0] VEC [NV] = '{
        {16'h0000, 16'h0000},  // R1 all divide-by-1
        {16'hF000, 16'hF000},  // R5 spare bits pass
        {16'h008F, 16'h0A8F},  // R2 mmu raised, R3 xbar raised to mmu
        {16'h0C0F, 16'h050F},  // R2 mmu lowered to spu+1
        {16'h030D, 16'h010D},  // R4 xbar lowered to per
        {16'h0030, 16'h0030},  // R4 ceiling beats cpu floor
        {16'hA467, 16'hA567},  // R3 raised then R4 lowered to lcd
        {16'hFFFF, 16'hFFFF},  // R2 top of range
        {16'h00CE, 16'h0ECE},  // R2 mmu to 3, R4 xbar to per
        {16'h5555, 16'h5555}   // R5 legal word unchanged
    };

    logic        clk = 0;
    logic        rst;
    logic        wr_en;
    logic [15:0] wr_data;
    logic [15:0] rd_data;
    logic [5:0]  gate_en;
    logic [5:0]  tick;
    logic        wdt_tick;

    int n_chk = 0;
    int n_fail = 0;
    int cnt [6];
    int wcnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    clk_ratio_divider u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .gate_en(gate_en), .tick(tick), .wdt_tick(wdt_tick)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_word(logic [15:0] w);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic count_ticks(int n);
        for (int d = 0; d < 6; d++) cnt[d] = 0;
        wcnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            for (int d = 0; d < 6; d++) cnt[d] += int'(tick[d]);
            wcnt += int'(wdt_tick);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        wr_en = 1'b0;
        wr_data = '0;
        gate_en = 6'h3f;
        idle(3);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 reset word", rd_data, 32'h0);
        check("R1 reset ticks", tick, 32'h3f);

        // R2..R5 legalizer vectors
        for (int v = 0; v < NV; v++) begin
            write_word(VEC[v][31:16]);
            check("R2/R3/R4/R5 legalized word", rd_data, VEC[v][15:0]);
        end

        // R6 hold
        idle(20);
        check("R6 hold", rd_data, VEC[NV-1][15:0]);

        // R7 rates: per 8, lcd 4, cpu 1, spu 2, xbar 4, mmu 4
        write_word(16'h0A4B);
        idle(16);
        count_ticks(48);
        check("R7 per rate", cnt[0], 6);
        check("R7 lcd rate", cnt[1], 12);
        check("R7 cpu rate", cnt[2], 48);
        check("R7 spu rate", cnt[3], 24);
        check("R7 xbar rate", cnt[4], 12);
        check("R7 mmu rate", cnt[5], 12);

        // R10 watchdog
        count_ticks(56);
        check("R10 wdt rate", wcnt, 4);

        // R8 gate low silences lcd only
        gate_en = 6'b111101;
        count_ticks(48);
        check("R8 gated lcd", cnt[1], 0);
        check("R8 ungated spu", cnt[3], 24);
        check("R10 wdt ignores gate", wcnt <= 4 && wcnt >= 3, 1);
        gate_en = 6'h3f;

        // R8/R9 after re-enable, all domains pulse with the div-8 domain
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            if (tick[0]) check("R9 coincident pulses", tick, 6'h3f);
        end

        // R9 div-8 grid survives writes to other fields
        begin
            int last = -1;
            for (int i = 0; i < 64; i++) begin
                @(negedge clk);
                if (tick[0]) begin
                    if (last >= 0) check("R9 frame spacing", i - last, 8);
                    last = i;
                end
                wr_en = (i % 5 == 2);
                wr_data = 16'((i * 16'h0137) | 16'h0003);
            end
            wr_en = 1'b0;
        end

        finish_run();
    end

endmodule